// File: doc/BRIEF.md
# Compact 8-bit Two-Accumulator Controller Core

This block is a small microcontroller core. It runs a program held in a 12 kB read-only region at $D000-$FFFF. It keeps two 8-bit accumulators, a 16-bit stack pointer, a 16-bit program counter and four condition flags (N, Z, V, C). It contains 512 bytes of working RAM at $0000-$01FF and two parallel ports. The first port is an output-only latch. The second port is bidirectional, and a per-bit direction register decides which of its pins the core drives.

The program store sits outside the core and is read through a 16-bit address output and an 8-bit data input. The surrounding logic, or a bench, decodes that read combinationally. Execution is multi-cycle with exactly one memory access per cycle. Each instruction therefore takes a fixed number of cycles, set by its addressing mode: immediate, extended, inherent or relative. There is no vector fetch: leaving reset starts execution at $D000. An opcode outside the supported set raises a one-cycle flag, is skipped as a one-byte no-op, and the core fetches the next byte.

Top module: `acc8_mcu`

## Requirements
- R1: While reset is low and on the first fetch after it, the core reads address $D000. The output-port latch, the bidirectional-port latch and its direction register are all zero.
- R2: Byte operations work on accumulator A (immediate $8x, extended $Bx) and on accumulator B (immediate $Cx, extended $Fx). The low nibble selects the operation: 0 subtract, 1 compare, 4 AND, 6 load, 8 XOR, A OR, B add. A compare does not change the accumulator.
- R3: Load, store, AND, OR and XOR set N and Z from their value, clear V and keep C. Add, subtract and compare set all four flags using carry/borrow and two's-complement overflow. BEQ ($27) branches when Z=1 and BNE ($26) branches when Z=0.
- R4: Extended stores of A ($B7) and B ($F7) write the byte at the 16-bit address. RAM holds what was stored at $0000-$01FF and returns it on extended reads.
- R5: Stack-pointer load ($8E immediate, $BE extended) and store ($BF) move 16 bits, with the high byte at the lower address.
- R6: A push ($36 A, $37 B) writes at the address in SP and then decrements SP. A pull ($32 A, $33 B) increments SP and then reads.
- R7: A relative branch adds its signed 8-bit offset to the address that follows it. BSR ($8D) pushes the return address low byte first and then the high byte. RTS ($39) restores it.
- R8: The output-port latch ($1004) changes only on a write to $1004.
- R9: The direction register ($1007) drives the output enables of the bidirectional port. The latch is written at $1003. A read of $1003 returns the pin for bits whose direction is 0 and the latch for bits whose direction is 1.
- R10: An undefined opcode (for example $41) raises `bad_opcode` for its single fetch cycle, changes no state except PC+1, and is followed by the fetch of the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_addr | output | 16 | Current bus address, for the program store |
| rom_data | input | 8 | Program byte at `rom_addr`, same cycle |
| portb_q | output | 8 | Output-only port latch |
| portc_in | input | 8 | Bidirectional port pin levels |
| portc_out | output | 8 | Bidirectional port latch value |
| portc_oe | output | 8 | Per-bit drive enable (direction register) |
| bad_opcode | output | 1 | High during the fetch of an undefined opcode |

## Verification
An instruction takes 1 cycle for an undefined opcode. It takes 2 cycles for 8-bit immediates, branches, pushes and pulls; 3 for RTS and for the 16-bit stack-pointer immediate; 4 for extended byte accesses and BSR; and 5 for 16-bit extended accesses. A port write becomes visible on the edge that ends the last cycle of its store. The bench does not count cycles per instruction. Each program ends in a branch-to-self loop, and the bench samples the ports on a falling edge well after the worst-case total for that program. The R1 and R10 checks are exact to the cycle: the fetch address is read on the first falling edge after reset is released, and `bad_opcode` is counted on each falling edge.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

  typedef enum logic [4:0] {
    S_FETCH, S_OPND, S_IMMH, S_IMML, S_EAH, S_EAL, S_RD, S_RDH, S_RDL,
    S_WR, S_WRH, S_WRL, S_BSRL, S_BSRH, S_PUSH, S_PULL, S_RTSH, S_RTSL
  } state_t;

  typedef enum logic [2:0] {
    AL_LD, AL_ADD, AL_SUB, AL_CMP, AL_AND, AL_OR, AL_EOR
  } alu_op_t;

  typedef enum logic [3:0] {
    K_ALU, K_STA, K_LDS, K_STS, K_BEQ, K_BNE, K_BSR, K_RTS, K_PSH, K_PUL, K_BAD
  } kind_t;

  typedef struct packed {
    kind_t   kind;
    alu_op_t op;
    logic    use_b;
    logic    ext;
  } dec_t;

  typedef struct packed {
    logic [7:0] res;
    logic       n, z, v, c;
    logic       wb;
  } alu_out_t;

  function automatic dec_t decode(input logic [7:0] opc);
    dec_t d;
    logic [3:0] hi;
    hi      = opc[7:4];
    d.kind  = K_BAD;
    d.op    = AL_LD;
    d.use_b = opc[6];
    d.ext   = opc[4];
    if (hi == 4'h8 || hi == 4'hB || hi == 4'hC || hi == 4'hF) begin
      case (opc[3:0])
        4'h0: begin d.kind = K_ALU; d.op = AL_SUB; end
        4'h1: begin d.kind = K_ALU; d.op = AL_CMP; end
        4'h4: begin d.kind = K_ALU; d.op = AL_AND; end
        4'h6: begin d.kind = K_ALU; d.op = AL_LD;  end
        4'h8: begin d.kind = K_ALU; d.op = AL_EOR; end
        4'hA: begin d.kind = K_ALU; d.op = AL_OR;  end
        4'hB: begin d.kind = K_ALU; d.op = AL_ADD; end
        4'h7: if (opc[4]) d.kind = K_STA;
        4'hE: if (!opc[6]) d.kind = K_LDS;
        4'hF: if (opc[4] && !opc[6]) d.kind = K_STS;
        4'hD: if (opc == 8'h8D) d.kind = K_BSR;
        default: d.kind = K_BAD;
      endcase
    end else begin
      d.use_b = opc[0];
      case (opc)
        8'h26:        d.kind = K_BNE;
        8'h27:        d.kind = K_BEQ;
        8'h39:        d.kind = K_RTS;
        8'h36, 8'h37: d.kind = K_PSH;
        8'h32, 8'h33: d.kind = K_PUL;
        default:      d.kind = K_BAD;
      endcase
    end
    return d;
  endfunction

  function automatic alu_out_t alu8(input alu_op_t op, input logic [7:0] a,
                                    input logic [7:0] b, input logic cin);
    alu_out_t o;
    logic [8:0] s;
    s    = 9'd0;
    o.wb = 1'b1;
    o.v  = 1'b0;
    o.c  = cin;
    case (op)
      AL_ADD: begin
        s     = {1'b0, a} + {1'b0, b};
        o.res = s[7:0];
        o.c   = s[8];
        o.v   = (a[7] == b[7]) && (s[7] != a[7]);
      end
      AL_SUB, AL_CMP: begin
        s     = {1'b0, a} - {1'b0, b};
        o.res = s[7:0];
        o.c   = s[8];
        o.v   = (a[7] != b[7]) && (s[7] != a[7]);
        o.wb  = (op == AL_SUB);
      end
      AL_AND:  o.res = a & b;
      AL_OR:   o.res = a | b;
      AL_EOR:  o.res = a ^ b;
      default: o.res = b;
    endcase
    o.n = o.res[7];
    o.z = (o.res == 8'd0);
    return o;
  endfunction

endpackage

// File: rtl/mcu_ram.sv
module mcu_ram #(
  parameter int BYTES = 512,
  localparam int AW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wd,
  output logic [7:0]    rd
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  assign rd = mem[addr];

  AST_RAM_KEEPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(addr)] == $past(wd))); // R4
endmodule

// File: rtl/mcu_ports.sv
module mcu_ports #(
  parameter logic [15:0] PC_ADDR  = 16'h1003,
  parameter logic [15:0] PB_ADDR  = 16'h1004,
  parameter logic [15:0] DDR_ADDR = 16'h1007
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        we,
  input  logic [7:0]  wd,
  input  logic [7:0]  pin_in,
  output logic [7:0]  rd,
  output logic        sel,
  output logic [7:0]  pb_q,
  output logic [7:0]  pc_q,
  output logic [7:0]  ddr_q
);
  logic hit_pc, hit_pb, hit_ddr;
  assign hit_pc  = (addr == PC_ADDR);
  assign hit_pb  = (addr == PB_ADDR);
  assign hit_ddr = (addr == DDR_ADDR);
  assign sel     = hit_pc | hit_pb | hit_ddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_q  <= '0;
      pc_q  <= '0;
      ddr_q <= '0;
    end else if (we) begin
      if (hit_pb)  pb_q  <= wd;
      if (hit_pc)  pc_q  <= wd;
      if (hit_ddr) ddr_q <= wd;
    end
  end

  always_comb begin
    rd = 8'h00;
    if (hit_pc)  rd = (pin_in & ~ddr_q) | (pc_q & ddr_q);
    if (hit_pb)  rd = pb_q;
    if (hit_ddr) rd = ddr_q;
  end

  AST_PORTB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit_pb) |=> $stable(pb_q)); // R8
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit_ddr) |=> $stable(ddr_q)); // R9
endmodule

// File: rtl/acc8_mcu.sv
module acc8_mcu
  import mcu_pkg::*;
#(
  parameter logic [15:0] RESET_PC  = 16'hD000,
  parameter logic [15:0] ROM_BASE  = 16'hD000,
  parameter int          RAM_BYTES = 512,
  parameter logic [15:0] PC_ADDR   = 16'h1003,
  parameter logic [15:0] PB_ADDR   = 16'h1004,
  parameter logic [15:0] DDR_ADDR  = 16'h1007
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] rom_addr,
  input  logic [7:0]  rom_data,
  output logic [7:0]  portb_q,
  input  logic [7:0]  portc_in,
  output logic [7:0]  portc_out,
  output logic [7:0]  portc_oe,
  output logic        bad_opcode
);
  localparam int RAM_AW = $clog2(RAM_BYTES);

  state_t      state;
  logic [15:0] pc, sp, ea;
  logic [7:0]  a_q, b_q, opc, tmp;
  logic        n_q, z_q, v_q, c_q, boot_q;

  logic [15:0] bus_a;
  logic [7:0]  bus_wd, rd, ram_rd, prt_rd;
  logic        bus_we, ram_sel, prt_sel;
  dec_t        dn, dq;
  alu_out_t    ao;
  logic [7:0]  acc_q;
  logic [15:0] sp_lds;

  assign dn    = decode(rd);
  assign dq    = decode(opc);
  assign acc_q = dq.use_b ? b_q : a_q;
  assign ao    = alu8(dq.op, acc_q, rd, c_q);
  assign sp_lds = {tmp, rd};

  // Bus address, write data and write strobe for the current state
  always_comb begin
    bus_a  = pc;
    bus_we = 1'b0;
    bus_wd = 8'h00;
    case (state)
      S_RD, S_RDH:  bus_a = ea;
      S_RDL:        bus_a = ea + 16'd1;
      S_WR:         begin bus_a = ea;         bus_we = 1'b1; bus_wd = acc_q;    end
      S_WRH:        begin bus_a = ea;         bus_we = 1'b1; bus_wd = sp[15:8]; end
      S_WRL:        begin bus_a = ea + 16'd1; bus_we = 1'b1; bus_wd = sp[7:0];  end
      S_BSRL:       begin bus_a = sp;         bus_we = 1'b1; bus_wd = pc[7:0];  end
      S_BSRH:       begin bus_a = sp;         bus_we = 1'b1; bus_wd = pc[15:8]; end
      S_PUSH:       begin bus_a = sp;         bus_we = 1'b1; bus_wd = acc_q;    end
      S_PULL, S_RTSH, S_RTSL: bus_a = sp + 16'd1;
      default:      bus_a = pc;
    endcase
  end

  assign ram_sel  = (bus_a < 16'(RAM_BYTES));
  assign rom_addr = bus_a;

  mcu_ram #(.BYTES(RAM_BYTES)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(bus_we && ram_sel),
    .addr(bus_a[RAM_AW-1:0]), .wd(bus_wd), .rd(ram_rd)
  );

  mcu_ports #(.PC_ADDR(PC_ADDR), .PB_ADDR(PB_ADDR), .DDR_ADDR(DDR_ADDR)) u_ports (
    .clk(clk), .rst_n(rst_n), .addr(bus_a), .we(bus_we), .wd(bus_wd),
    .pin_in(portc_in), .rd(prt_rd), .sel(prt_sel),
    .pb_q(portb_q), .pc_q(portc_out), .ddr_q(portc_oe)
  );

  always_comb begin
    if (ram_sel)               rd = ram_rd;
    else if (prt_sel)          rd = prt_rd;
    else if (bus_a >= ROM_BASE) rd = rom_data;
    else                       rd = 8'h00;
  end

  // Named events for the checks below
  logic sp_dn, sp_up, alu_fire, logic_fire;
  assign bad_opcode = (state == S_FETCH) && (dn.kind == K_BAD);
  assign sp_dn      = (state == S_PUSH) || (state == S_BSRL) || (state == S_BSRH);
  assign sp_up      = (state == S_PULL) || (state == S_RTSH) || (state == S_RTSL);
  assign alu_fire   = (state == S_RD) || (state == S_OPND && dq.kind == K_ALU);
  assign logic_fire = alu_fire && (dq.op inside {AL_LD, AL_AND, AL_OR, AL_EOR});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc <= RESET_PC; sp <= '0; ea <= '0;
      a_q <= '0; b_q <= '0; opc <= '0; tmp <= '0;
      n_q <= 1'b0; z_q <= 1'b0; v_q <= 1'b0; c_q <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      case (state)
        S_FETCH: begin
          boot_q <= 1'b0;
          opc    <= rd;
          pc     <= pc + 16'd1;
          case (dn.kind)
            K_ALU:        state <= dn.ext ? S_EAH : S_OPND;
            K_STA, K_STS: state <= S_EAH;
            K_LDS:        state <= dn.ext ? S_EAH : S_IMMH;
            K_BEQ, K_BNE, K_BSR: state <= S_OPND;
            K_RTS:        state <= S_RTSH;
            K_PSH:        state <= S_PUSH;
            K_PUL:        state <= S_PULL;
            default:      state <= S_FETCH;
          endcase
        end
        S_OPND: begin
          pc    <= pc + 16'd1;
          state <= S_FETCH;
          if ((dq.kind == K_BEQ && z_q) || (dq.kind == K_BNE && !z_q))
            pc <= pc + 16'd1 + {{8{rd[7]}}, rd};
          if (dq.kind == K_BSR) begin
            tmp   <= rd;
            state <= S_BSRL;
          end
        end
        S_IMMH: begin tmp <= rd; pc <= pc + 16'd1; state <= S_IMML; end
        S_IMML, S_RDL: begin
          if (state == S_IMML) pc <= pc + 16'd1;
          sp  <= sp_lds;
          n_q <= sp_lds[15]; z_q <= (sp_lds == 16'd0); v_q <= 1'b0;
          state <= S_FETCH;
        end
        S_EAH: begin ea[15:8] <= rd; pc <= pc + 16'd1; state <= S_EAL; end
        S_EAL: begin
          ea[7:0] <= rd;
          pc      <= pc + 16'd1;
          case (dq.kind)
            K_STA:   state <= S_WR;
            K_STS:   state <= S_WRH;
            K_LDS:   state <= S_RDH;
            default: state <= S_RD;
          endcase
        end
        S_RDH: begin tmp <= rd; state <= S_RDL; end
        S_WR: begin
          n_q <= acc_q[7]; z_q <= (acc_q == 8'd0); v_q <= 1'b0;
          state <= S_FETCH;
        end
        S_WRH: state <= S_WRL;
        S_WRL: begin
          n_q <= sp[15]; z_q <= (sp == 16'd0); v_q <= 1'b0;
          state <= S_FETCH;
        end
        S_BSRL: begin sp <= sp - 16'd1; state <= S_BSRH; end
        S_BSRH: begin
          sp    <= sp - 16'd1;
          pc    <= pc + {{8{tmp[7]}}, tmp};
          state <= S_FETCH;
        end
        S_PUSH: begin sp <= sp - 16'd1; state <= S_FETCH; end
        S_PULL: begin
          sp <= sp + 16'd1;
          if (dq.use_b) b_q <= rd; else a_q <= rd;
          state <= S_FETCH;
        end
        S_RTSH: begin sp <= sp + 16'd1; tmp <= rd; state <= S_RTSL; end
        S_RTSL: begin sp <= sp + 16'd1; pc <= {tmp, rd}; state <= S_FETCH; end
        default: state <= S_FETCH;
      endcase
      if (alu_fire) begin
        if (ao.wb) begin
          if (dq.use_b) b_q <= ao.res; else a_q <= ao.res;
        end
        n_q <= ao.n; z_q <= ao.z; v_q <= ao.v; c_q <= ao.c;
      end
    end
  end

  AST_BOOT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && boot_q) |-> (rom_addr == RESET_PC)); // R1
  AST_LOGIC_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
    logic_fire |=> (!v_q && c_q == $past(c_q))); // R3
  AST_PUSH_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    sp_dn |=> (sp == $past(sp) - 16'd1)); // R6
  AST_PULL_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    sp_up |=> (sp == $past(sp) + 16'd1)); // R6
  AST_BAD_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    bad_opcode |=> (state == S_FETCH && pc == $past(pc) + 16'd1 &&
                    $stable(a_q) && $stable(b_q) && $stable(sp))); // R10
  AST_ONE_STORE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, prt_sel})); // R4
endmodule

// File: tb/acc8_mcu_tb.sv
`timescale 1ns/1ps
module acc8_mcu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rom_addr;
  logic [7:0]  rom_data;
  logic [7:0]  portb_q, portc_out, portc_oe;
  logic [7:0]  portc_in = 8'h00;
  logic        bad_opcode;
  logic [7:0]  img [256];
  int          n_chk = 0, n_fail = 0, bad_cnt = 0;

  always #5 clk = ~clk;

  assign rom_data = (rom_addr >= 16'hD000 && rom_addr < 16'hD100) ? img[rom_addr[7:0]] : 8'h00;

  acc8_mcu u_dut (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .portb_q(portb_q), .portc_in(portc_in), .portc_out(portc_out),
    .portc_oe(portc_oe), .bad_opcode(bad_opcode)
  );

  always @(negedge clk) if (rst_n && bad_opcode) bad_cnt++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic blank();
    for (int i = 0; i < 256; i++) img[i] = 8'h00;
  endtask

  task automatic put(input int at, input logic [7:0] v [$]);
    foreach (v[i]) img[at + i] = v[i];
  endtask

  // Reset, release on a falling edge, then run
  task automatic run(input int cycles, input bit check_reset);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    if (check_reset) begin
      chk("R1 portb reset", {8'h0, portb_q}, 16'h0000);
      chk("R1 ddr reset", {8'h0, portc_oe}, 16'h0000);
      chk("R1 latch reset", {8'h0, portc_out}, 16'h0000);
    end
    rst_n = 1'b1;
    bad_cnt = 0;
    #1;
    if (check_reset) chk("R1 first fetch", rom_addr, 16'hD000);
    repeat (cycles) @(negedge clk);
  endtask

  // Reference model for the byte operations, by low opcode nibble
  function automatic logic [8:0] model(input logic [3:0] lo, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, val;
    case (lo)
      4'h0: begin val = a - b; acc = val; end
      4'h1: begin val = a - b; acc = a;   end
      4'h4: begin val = a & b; acc = val; end
      4'h6: begin val = b;     acc = val; end
      4'h8: begin val = a ^ b; acc = val; end
      4'hA: begin val = a | b; acc = val; end
      default: begin val = a + b; acc = val; end
    endcase
    return {(val == 8'd0), acc};
  endfunction

  initial begin
    logic [3:0] los [7] = '{4'h0, 4'h1, 4'h4, 4'h6, 4'h8, 4'hA, 4'hB};
    void'($urandom(32'd2718));

    // Random immediate byte operations on A or B; Z seen through BEQ (R2, R3)
    for (int it = 0; it < 40; it++) begin
      logic [7:0] a, b, base, ldi, op, st;
      logic [3:0] lo;
      logic [8:0] m;
      bit use_b;
      lo    = los[$urandom_range(0, 6)];
      use_b = $urandom_range(0, 1) == 1;
      a     = 8'($urandom);
      b     = (it % 8 == 3) ? a : 8'($urandom);
      if (it == 5) begin a = 8'h00; b = 8'h00; end
      base  = use_b ? 8'hC0 : 8'h80;
      ldi   = base | 8'h06;
      op    = base | {4'h0, lo};
      st    = use_b ? 8'hF7 : 8'hB7;
      blank();
      put(8'h00, '{8'h86, 8'hFF, 8'hB7, 8'h10, 8'h03, ldi, a, op, b,
                   8'h27, 8'h03, st, 8'h10, 8'h03, st, 8'h10, 8'h04,
                   8'h86, 8'h00, 8'h27, 8'hFE});
      run(60, it == 0);
      m = model(lo, a, b);
      chk("R2 accumulator result", {8'h0, portb_q}, {8'h0, m[7:0]});
      chk("R3 zero flag via BEQ", {8'h0, portc_out}, {8'h0, m[8] ? 8'hFF : m[7:0]});
    end

    // R4: extended store and reload through RAM at its top byte, extended add
    blank();
    put(8'h00, '{8'h86, 8'h5A, 8'hB7, 8'h01, 8'hFF, 8'hC6, 8'h11, 8'hFB, 8'h01, 8'hFF,
                 8'hF7, 8'h10, 8'h04, 8'h86, 8'h00, 8'h27, 8'hFE});
    run(60, 0);
    chk("R4 RAM store then extended add", {8'h0, portb_q}, 16'h006B);

    // R5: 16-bit stack pointer load and store, high byte first
    blank();
    put(8'h00, '{8'h8E, 8'h12, 8'h34, 8'hBF, 8'h00, 8'h10, 8'hB6, 8'h00, 8'h10,
                 8'hB7, 8'h10, 8'h04, 8'hF6, 8'h00, 8'h11, 8'hF7, 8'h10, 8'h03,
                 8'h86, 8'h00, 8'h27, 8'hFE});
    run(60, 0);
    chk("R5 SP high byte at lower address", {8'h0, portb_q}, 16'h0012);
    chk("R5 SP low byte at next address", {8'h0, portc_out}, 16'h0034);

    // R6: push A, pull into B, inspect the byte under the initial SP
    blank();
    put(8'h00, '{8'h8E, 8'h01, 8'hFF, 8'h86, 8'h9C, 8'h36, 8'h86, 8'h00, 8'h33,
                 8'hF7, 8'h10, 8'h04, 8'hB6, 8'h01, 8'hFF, 8'hB7, 8'h10, 8'h03,
                 8'h86, 8'h00, 8'h27, 8'hFE});
    run(60, 0);
    chk("R6 pulled value", {8'h0, portb_q}, 16'h009C);
    chk("R6 push wrote at SP", {8'h0, portc_out}, 16'h009C);

    // R7: BSR to a subroutine at D015 and RTS back to D005
    blank();
    put(8'h00, '{8'h8E, 8'h01, 8'hFF, 8'h8D, 8'h10, 8'hB7, 8'h10, 8'h04,
                 8'hB6, 8'h01, 8'hFF, 8'hB7, 8'h10, 8'h03, 8'h86, 8'h00, 8'h27, 8'hFE});
    put(8'h15, '{8'h86, 8'h3C, 8'h39});
    run(80, 0);
    chk("R7 subroutine result after RTS", {8'h0, portb_q}, 16'h003C);
    chk("R7 return low byte pushed first", {8'h0, portc_out}, 16'h0005);

    // R7: backward BNE loop three times, B += 2 each pass
    blank();
    put(8'h00, '{8'h86, 8'h03, 8'hC6, 8'h00, 8'hCB, 8'h02, 8'h80, 8'h01, 8'h26, 8'hFA,
                 8'hF7, 8'h10, 8'h04, 8'h86, 8'h00, 8'h27, 8'hFE});
    run(80, 0);
    chk("R7 backward branch loop", {8'h0, portb_q}, 16'h0006);

    // R8: writes to neighbours of the output port leave it alone
    blank();
    put(8'h00, '{8'h86, 8'h44, 8'hB7, 8'h10, 8'h04, 8'h86, 8'h99, 8'hB7, 8'h10, 8'h05,
                 8'hB7, 8'h10, 8'h03, 8'h86, 8'h00, 8'h27, 8'hFE});
    run(60, 0);
    chk("R8 output latch unchanged by other writes", {8'h0, portb_q}, 16'h0044);

    // R9: mixed-direction read of the bidirectional port
    portc_in = 8'h3C;
    blank();
    put(8'h00, '{8'h86, 8'h0F, 8'hB7, 8'h10, 8'h07, 8'h86, 8'hA5, 8'hB7, 8'h10, 8'h03,
                 8'hB6, 8'h10, 8'h03, 8'hB7, 8'h10, 8'h04, 8'h86, 8'h00, 8'h27, 8'hFE});
    run(60, 0);
    chk("R9 mixed read", {8'h0, portb_q}, 16'h0035);
    chk("R9 drive enables", {8'h0, portc_oe}, 16'h000F);
    chk("R9 latch", {8'h0, portc_out}, 16'h00A5);

    // R10: undefined opcode then normal code
    blank();
    put(8'h00, '{8'h41, 8'h86, 8'h77, 8'hB7, 8'h10, 8'h04, 8'h86, 8'h00, 8'h27, 8'hFE});
    run(60, 0);
    chk("R10 execution continues", {8'h0, portb_q}, 16'h0077);
    chk("R10 flag pulses once", 16'(bad_cnt), 16'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule